// File: doc/BRIEF.md
# Hot Code Region Profiler

This block sits beside the fetch stage of a core that runs translated code. It watches a strobe that fires each time a code block starts executing, together with the block's start address, and works out which blocks run often enough to be worth compiling. Candidates live in a small associative frequency table, one execution counter per block. Every counter loses one count at a fixed interval, so a block that stops running drains to zero and gives up its slot.

When a block's count reaches the hot threshold, it leaves the frequency table and enters a second table of the same size. That table follows compiled blocks. A single event strobe, tagged with a block address, reports the expensive events a compiled block causes: cache misses, TLB misses, branch mispredictions, alias mispredictions and I/O accesses. Each block has one cost counter, which decays on the same interval. When a block's cost count reaches the cost threshold, the block is queued for recompilation and its cost count restarts from zero.

Compile and recompile requests wait in a short queue. The translator reads it through a valid/ready handshake. Each request carries a block address and a flag that tells a recompile from a first compile. The hot threshold, the cost threshold and the decay interval are captured from configuration inputs while reset is held.

Top module: `hot_region_profiler`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_valid` is 0, and both tables and the queue are empty.
- R2: An executed block that is not yet tracked takes the lowest-index free slot of the frequency table with a count of 1. Each further execution adds 1, saturating at 2^CNT_W-1. On the clock edge where the count reaches the hot threshold, a request is queued with `req_recomp`=0 (compile) and the block's address. It is visible at the ports after that edge.
- R3: When the frequency table has no free slot, an execution of an untracked block changes nothing.
- R4: Decay happens on every P-th clock after reset, where P is the captured interval (1 means every clock). It subtracts 1 from every nonzero count in both tables. A frequency entry that reaches 0 becomes free. An entry that is incremented or inserted in a decay cycle is not decremented in that cycle.
- R5: A promoted block leaves the frequency table and enters the cost table with a cost count of 0. After that, executions of its address have no effect.
- R6: An event whose address is in the cost table adds 1 to that block's cost count. When the count reaches the cost threshold, a request with `req_recomp`=1 is queued and the count restarts at 0.
- R7: An event whose address is not in the cost table has no effect.
- R8: When the cost table is full, a promotion replaces the entry with the lowest cost count, the lowest index winning ties. The evicted block no longer counts events.
- R9: The request queue is first in, first out, holding Q_DEPTH entries. A request is dropped if its address is already queued, or if the queue is full. A compile request from the same cycle is placed ahead of a recompile request. While `req_valid`=1 and `req_ready`=0, the outputs hold.
- R10: The thresholds and the interval are captured only while `rst`=1. Changing the configuration inputs afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_hot_thr | input | CNT_W | Execution count that promotes a block (2 or more) |
| cfg_cost_thr | input | CNT_W | Cost count that triggers recompilation (1 or more) |
| cfg_decay_period | input | PERIOD_W | Clocks between decay steps |
| exec_valid | input | 1 | A code block started executing |
| exec_addr | input | ADDR_W | Start address of that block |
| evt_valid | input | 1 | A costly event occurred |
| evt_addr | input | ADDR_W | Block address the event is charged to |
| req_valid | output | 1 | A compile or recompile request is waiting |
| req_ready | input | 1 | The consumer takes the request at the clock edge |
| req_addr | output | ADDR_W | Block address of the head request |
| req_recomp | output | 1 | 1 for a recompile request, 0 for a first compile |

## Verification
A wrong count, tag or valid bit inside either table cannot be seen at once. It shows up as a request that comes early, comes late or never comes, for that block's next crossing of a threshold. Depending on the thresholds and the decay interval, that can be several executions or events away. A broken queue shows within a cycle, as a wrong head address, a lost entry or a duplicate. The bench therefore compares the three request outputs against a behavioural model on every clock. It also drives exact sequences whose crossing cycle is known, so that a table error is caught on the very cycle the request should have appeared.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  // Kind of request leaving the queue
  typedef enum logic {
    REQ_COMPILE   = 1'b0,
    REQ_RECOMPILE = 1'b1
  } req_kind_e;
endpackage

// File: rtl/hrp_freq_tab.sv
// Frequency table: finds blocks that execute often.
module hrp_freq_tab #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] thr,
  input  logic          exec_v,
  input  logic [AW-1:0] exec_a,
  input  logic          blocked,
  input  logic          decay,
  output logic          promote,
  output logic [AW-1:0] promote_a
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [N-1:0]  vld;
  logic [AW-1:0] tag [N];
  logic [CW-1:0] cnt [N];
  logic [N-1:0]  hit_vec;
  logic          hit, have_free, act;
  logic [IW-1:0] hidx, fidx;
  logic [CW-1:0] bumped;

  always_comb begin
    hit = 1'b0;
    hidx = '0;
    have_free = 1'b0;
    fidx = '0;
    // descending scan leaves the lowest matching index
    for (int i = N - 1; i >= 0; i--) begin
      hit_vec[i] = vld[i] && (tag[i] == exec_a);
      if (hit_vec[i]) begin
        hit = 1'b1;
        hidx = IW'(i);
      end
      if (!vld[i]) begin
        have_free = 1'b1;
        fidx = IW'(i);
      end
    end
    act = exec_v && !blocked;
    bumped = (cnt[hidx] == CMAX) ? CMAX : cnt[hidx] + 1'b1;
    promote = act && hit && (bumped >= thr);
    promote_a = exec_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < N; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (act && hit && hidx == IW'(i)) begin
          if (promote) begin
            vld[i] <= 1'b0;
            cnt[i] <= '0;
          end else begin
            cnt[i] <= bumped;
          end
        end else if (act && !hit && have_free && fidx == IW'(i)) begin
          vld[i] <= 1'b1;
          cnt[i] <= CW'(1);
        end else if (decay && vld[i]) begin
          cnt[i] <= cnt[i] - 1'b1;
          if (cnt[i] == CW'(1)) vld[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (act && !hit && have_free) tag[fidx] <= exec_a;
  end

  assert_unique_tag_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(hit_vec) <= 1);

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_live_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
      vld[g] |-> (cnt[g] != '0));
  end
endmodule

// File: rtl/hrp_cost_tab.sv
// Cost table: charges costly events to compiled blocks.
module hrp_cost_tab #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] thr,
  input  logic          ins_v,
  input  logic [AW-1:0] ins_a,
  input  logic          evt_v,
  input  logic [AW-1:0] evt_a,
  input  logic [AW-1:0] look_a,
  input  logic          decay,
  output logic          look_hit,
  output logic          recomp,
  output logic [AW-1:0] recomp_a
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [N-1:0]  vld;
  logic [AW-1:0] tag [N];
  logic [CW-1:0] cnt [N];
  logic          ehit, have_free, ev_on;
  logic [IW-1:0] eidx, fidx, vidx, midx;
  logic [CW-1:0] ebump, best;

  always_comb begin
    ehit = 1'b0;
    eidx = '0;
    have_free = 1'b0;
    fidx = '0;
    look_hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && tag[i] == evt_a) begin
        ehit = 1'b1;
        eidx = IW'(i);
      end
      if (!vld[i]) begin
        have_free = 1'b1;
        fidx = IW'(i);
      end
      if (vld[i] && tag[i] == look_a) look_hit = 1'b1;
    end
    // lowest count, strict compare keeps the lowest index on ties
    best = cnt[0];
    midx = '0;
    for (int i = 1; i < N; i++) begin
      if (cnt[i] < best) begin
        best = cnt[i];
        midx = IW'(i);
      end
    end
    vidx = have_free ? fidx : midx;
    ev_on = evt_v && ehit && !(ins_v && eidx == vidx);
    ebump = (cnt[eidx] == CMAX) ? CMAX : cnt[eidx] + 1'b1;
    recomp = ev_on && (ebump >= thr);
    recomp_a = evt_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < N; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ins_v && vidx == IW'(i)) begin
          vld[i] <= 1'b1;
          cnt[i] <= '0;
        end else if (ev_on && eidx == IW'(i)) begin
          cnt[i] <= recomp ? '0 : ebump;
        end else if (decay && cnt[i] != '0) begin
          cnt[i] <= cnt[i] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins_v) tag[vidx] <= ins_a;
  end

  assert_recomp_clears_R6: assert property (@(posedge clk) disable iff (rst)
    recomp |=> (cnt[$past(eidx)] == '0));
endmodule

// File: rtl/hrp_req_q.sv
// Request queue with two push ports, dropping duplicates.
module hrp_req_q
  import hrp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p0_v,
  input  logic [AW-1:0] p0_a,
  input  req_kind_e     p0_k,
  input  logic          p1_v,
  input  logic [AW-1:0] p1_a,
  input  req_kind_e     p1_k,
  output logic          out_v,
  input  logic          out_rdy,
  output logic [AW-1:0] out_a,
  output req_kind_e     out_k
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = PW + 1;
  localparam logic [NW-1:0] FULL = NW'(DEPTH);

  logic [AW-1:0] slot_a [DEPTH];
  req_kind_e     slot_k [DEPTH];
  logic [PW-1:0] head, tail, off;
  logic [NW-1:0] count;
  logic          dup0, dup1, acc0, acc1, pop;

  always_comb begin
    dup0 = 1'b0;
    dup1 = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      off = PW'(i) - head;
      if ({1'b0, off} < count) begin
        if (slot_a[i] == p0_a) dup0 = 1'b1;
        if (slot_a[i] == p1_a) dup1 = 1'b1;
      end
    end
    acc0 = p0_v && !dup0 && (count < FULL);
    acc1 = p1_v && !dup1 && !(acc0 && p0_a == p1_a) && ((count + NW'(acc0)) < FULL);
    out_v = (count != '0);
    pop = out_v && out_rdy;
    out_a = slot_a[head];
    out_k = slot_k[head];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      count <= '0;
    end else begin
      tail <= tail + PW'(acc0) + PW'(acc1);
      head <= head + PW'(pop);
      count <= count + NW'(acc0) + NW'(acc1) - NW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (acc0) begin
      slot_a[tail] <= p0_a;
      slot_k[tail] <= p0_k;
    end
    if (acc1) begin
      slot_a[tail + PW'(acc0)] <= p1_a;
      slot_k[tail + PW'(acc0)] <= p1_k;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_v && !out_rdy) |=> (out_v && $stable(out_a) && $stable(out_k)));
endmodule

// File: rtl/hot_region_profiler.sv
module hot_region_profiler
  import hrp_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 4,
  parameter int Q_DEPTH   = 4,
  parameter int PERIOD_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cfg_hot_thr,
  input  logic [CNT_W-1:0]    cfg_cost_thr,
  input  logic [PERIOD_W-1:0] cfg_decay_period,
  input  logic                exec_valid,
  input  logic [ADDR_W-1:0]   exec_addr,
  input  logic                evt_valid,
  input  logic [ADDR_W-1:0]   evt_addr,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic                req_recomp
);
  logic [CNT_W-1:0]    hot_thr_q, cost_thr_q;
  logic [PERIOD_W-1:0] period_q, dcnt;
  logic                decay;
  logic                promote, cost_hit, recomp;
  logic [ADDR_W-1:0]   promote_a, recomp_a;
  req_kind_e           head_k;

  // configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      hot_thr_q <= cfg_hot_thr;
      cost_thr_q <= cfg_cost_thr;
      period_q <= cfg_decay_period;
    end
  end

  assign decay = ({1'b0, dcnt} + 1'b1) >= {1'b0, period_q};

  always_ff @(posedge clk) begin
    if (rst) dcnt <= '0;
    else dcnt <= decay ? '0 : dcnt + 1'b1;
  end

  hrp_freq_tab #(.N(N_ENTRIES), .AW(ADDR_W), .CW(CNT_W)) u_freq (
    .clk(clk), .rst(rst), .thr(hot_thr_q),
    .exec_v(exec_valid), .exec_a(exec_addr), .blocked(cost_hit),
    .decay(decay), .promote(promote), .promote_a(promote_a)
  );

  hrp_cost_tab #(.N(N_ENTRIES), .AW(ADDR_W), .CW(CNT_W)) u_cost (
    .clk(clk), .rst(rst), .thr(cost_thr_q),
    .ins_v(promote), .ins_a(promote_a),
    .evt_v(evt_valid), .evt_a(evt_addr), .look_a(exec_addr),
    .decay(decay), .look_hit(cost_hit),
    .recomp(recomp), .recomp_a(recomp_a)
  );

  hrp_req_q #(.AW(ADDR_W), .DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst(rst),
    .p0_v(promote), .p0_a(promote_a), .p0_k(REQ_COMPILE),
    .p1_v(recomp), .p1_a(recomp_a), .p1_k(REQ_RECOMPILE),
    .out_v(req_valid), .out_rdy(req_ready), .out_a(req_addr), .out_k(head_k)
  );

  assign req_recomp = (head_k == REQ_RECOMPILE);

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(hot_thr_q) && $stable(cost_thr_q) && $stable(period_q)));
endmodule

// File: tb/sim_hot_region_profiler.sv
`timescale 1ns/1ps
module sim_hot_region_profiler;
  localparam int N = 4, AW = 16, CW = 4, QD = 4, PWD = 16;
  localparam int CMAX = 15;

  logic clk = 0, rst = 1;
  logic [CW-1:0] cfg_hot_thr = 3, cfg_cost_thr = 2;
  logic [PWD-1:0] cfg_decay_period = 1000;
  logic exec_valid = 0, evt_valid = 0, req_ready = 0;
  logic [AW-1:0] exec_addr = 0, evt_addr = 0;
  logic req_valid, req_recomp;
  logic [AW-1:0] req_addr;

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  hot_region_profiler #(.N_ENTRIES(N), .ADDR_W(AW), .CNT_W(CW), .Q_DEPTH(QD), .PERIOD_W(PWD)) u0 (
    .clk(clk), .rst(rst), .cfg_hot_thr(cfg_hot_thr), .cfg_cost_thr(cfg_cost_thr),
    .cfg_decay_period(cfg_decay_period), .exec_valid(exec_valid), .exec_addr(exec_addr),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_recomp(req_recomp));

  // behavioural reference model
  bit fv[N], cv[N];
  int ft[N], fc[N], ct[N], cc[N];
  int qa[$];
  bit qk[$];
  int m_hot, m_cost, m_per, m_dcnt;

  always @(posedge clk) begin : model
    int h, f, e, v, bump, eb, sz;
    bit blk, act, prom, ev_on, rc, acc0, acc1, dup0, dup1, dec;
    if (rst) begin
      m_hot = cfg_hot_thr; m_cost = cfg_cost_thr; m_per = cfg_decay_period; m_dcnt = 0;
      for (int j = 0; j < N; j++) begin fv[j] = 0; cv[j] = 0; fc[j] = 0; cc[j] = 0; end
      qa.delete(); qk.delete();
    end else begin
      dec = (m_dcnt + 1 >= m_per);
      m_dcnt = dec ? 0 : m_dcnt + 1;
      blk = 0;
      for (int j = 0; j < N; j++) if (cv[j] && ct[j] == exec_addr) blk = 1;
      act = exec_valid && !blk;
      h = -1; f = -1;
      for (int j = 0; j < N; j++) begin
        if (h < 0 && fv[j] && ft[j] == exec_addr) h = j;
        if (f < 0 && !fv[j]) f = j;
      end
      bump = (h >= 0) ? ((fc[h] + 1 > CMAX) ? CMAX : fc[h] + 1) : 0;
      prom = act && h >= 0 && bump >= m_hot;
      e = -1; v = -1;
      for (int j = 0; j < N; j++) begin
        if (e < 0 && cv[j] && ct[j] == evt_addr) e = j;
        if (v < 0 && !cv[j]) v = j;
      end
      if (v < 0) begin
        v = 0;
        for (int j = 1; j < N; j++) if (cc[j] < cc[v]) v = j;
      end
      ev_on = evt_valid && e >= 0 && !(prom && e == v);
      eb = (e >= 0) ? ((cc[e] + 1 > CMAX) ? CMAX : cc[e] + 1) : 0;
      rc = ev_on && eb >= m_cost;
      sz = qa.size(); dup0 = 0; dup1 = 0;
      foreach (qa[j]) begin
        if (qa[j] == exec_addr) dup0 = 1;
        if (qa[j] == evt_addr) dup1 = 1;
      end
      acc0 = prom && !dup0 && sz < QD;
      acc1 = rc && !dup1 && !(acc0 && exec_addr == evt_addr) && (sz + int'(acc0)) < QD;
      if (sz > 0 && req_ready) begin void'(qa.pop_front()); void'(qk.pop_front()); end
      if (acc0) begin qa.push_back(exec_addr); qk.push_back(0); end
      if (acc1) begin qa.push_back(evt_addr); qk.push_back(1); end
      for (int j = 0; j < N; j++) begin
        if (act && h == j) begin
          if (prom) begin fv[j] = 0; fc[j] = 0; end else fc[j] = bump;
        end else if (act && h < 0 && f == j) begin
          fv[j] = 1; ft[j] = exec_addr; fc[j] = 1;
        end else if (dec && fv[j]) begin
          fc[j]--; if (fc[j] == 0) fv[j] = 0;
        end
      end
      for (int j = 0; j < N; j++) begin
        if (prom && v == j) begin cv[j] = 1; ct[j] = exec_addr; cc[j] = 0; end
        else if (ev_on && e == j) cc[j] = rc ? 0 : eb;
        else if (dec && cc[j] > 0) cc[j]--;
      end
    end
  end

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (req_valid !== (qa.size() > 0) ||
          (qa.size() > 0 && (req_addr !== AW'(qa[0]) || req_recomp !== qk[0]))) begin
        failures++;
        $display("FAIL %s model: valid=%0b addr=%h recomp=%0b expected valid=%0b addr=%h recomp=%0b",
                 tag, req_valid, req_addr, req_recomp, qa.size() > 0,
                 (qa.size() > 0) ? qa[0] : 0, (qa.size() > 0) ? qk[0] : 0);
      end
    end
  end

  task automatic expect_out(input bit v, input int a, input bit k, input string t);
    checks++;
    if (req_valid !== v || (v && (req_addr !== AW'(a) || req_recomp !== k))) begin
      failures++;
      $display("FAIL %s: valid=%0b addr=%h recomp=%0b expected valid=%0b addr=%h recomp=%0b",
               t, req_valid, req_addr, req_recomp, v, a, k);
    end
  endtask

  task automatic do_reset(input int hot, input int cost, input int per);
    rst = 1; cfg_hot_thr = CW'(hot); cfg_cost_thr = CW'(cost); cfg_decay_period = PWD'(per);
    exec_valid = 0; evt_valid = 0; req_ready = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic ex(input int a);
    exec_valid = 1; exec_addr = AW'(a);
    @(negedge clk);
    exec_valid = 0;
  endtask

  task automatic ev(input int a);
    evt_valid = 1; evt_addr = AW'(a);
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop();
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
  endtask

  initial begin
    @(negedge clk);
    // R1 reset state
    tag = "R1";
    do_reset(3, 2, 1000);
    expect_out(0, 0, 0, "R1");
    // R2 promotion on reaching the hot threshold
    tag = "R2";
    ex(16'h0100); ex(16'h0100);
    expect_out(0, 0, 0, "R2");
    ex(16'h0100);
    expect_out(1, 16'h0100, 0, "R2");
    pop();
    expect_out(0, 0, 0, "R2");
    // R5 promoted block ignores executions
    tag = "R5";
    ex(16'h0100); ex(16'h0100); ex(16'h0100); ex(16'h0100);
    expect_out(0, 0, 0, "R5");
    // R6 recompile on reaching the cost threshold
    tag = "R6";
    ev(16'h0100); ev(16'h0100);
    expect_out(1, 16'h0100, 1, "R6");
    pop();
    ev(16'h0100);
    expect_out(0, 0, 0, "R6");
    ev(16'h0100);
    expect_out(1, 16'h0100, 1, "R6");
    pop();
    // R7 events for unknown blocks
    tag = "R7";
    for (int i = 0; i < 4; i++) ev(16'h0999);
    expect_out(0, 0, 0, "R7");

    // R3 full frequency table
    tag = "R3";
    do_reset(3, 2, 1000);
    ex(16'h0B00); ex(16'h0C00); ex(16'h0D00); ex(16'h0E00);
    ex(16'h0F00); ex(16'h0F00); ex(16'h0F00);
    expect_out(0, 0, 0, "R3");
    ex(16'h0B00); ex(16'h0B00);
    expect_out(1, 16'h0B00, 0, "R3");

    // R4 decay every clock; increment beats decay
    tag = "R4";
    do_reset(3, 2, 1);
    ex(16'h0A00); ex(16'h0A00); ex(16'h0A00);
    expect_out(1, 16'h0A00, 0, "R4");
    pop();
    ex(16'h0B00); idle(1); ex(16'h0B00); ex(16'h0B00);
    expect_out(0, 0, 0, "R4");
    ex(16'h0B00);
    expect_out(1, 16'h0B00, 0, "R4");
    pop();
    do_reset(3, 2, 4);
    ex(16'h0C00); idle(10); ex(16'h0C00); ex(16'h0C00);
    expect_out(0, 0, 0, "R4");

    // R8 replacement in a full cost table
    tag = "R8";
    do_reset(2, 2, 1000);
    for (int p = 0; p < 4; p++) begin ex(16'h1000 + p); ex(16'h1000 + p); end
    for (int p = 0; p < 4; p++) begin expect_out(1, 16'h1000 + p, 0, "R8"); pop(); end
    ev(16'h1000); ev(16'h1001); ev(16'h1002);
    ex(16'h1004); ex(16'h1004);
    expect_out(1, 16'h1004, 0, "R8");
    pop();
    ev(16'h1003); ev(16'h1003);
    expect_out(0, 0, 0, "R8");
    ev(16'h1004); ev(16'h1004);
    expect_out(1, 16'h1004, 1, "R8");
    ev(16'h1000);
    pop();
    expect_out(1, 16'h1000, 1, "R8");
    pop();

    // R9 ordering, duplicate drop, full drop
    tag = "R9";
    do_reset(2, 2, 1000);
    ex(16'h2000); ex(16'h2000); ex(16'h2001); ex(16'h2001);
    ev(16'h2000); ev(16'h2000);
    ex(16'h2002); ex(16'h2002); ex(16'h2003); ex(16'h2003); ex(16'h2004); ex(16'h2004);
    idle(3);
    for (int p = 0; p < 4; p++) begin expect_out(1, 16'h2000 + p, 0, "R9"); pop(); end
    expect_out(0, 0, 0, "R9");

    // R10 configuration frozen after reset
    tag = "R10";
    do_reset(3, 2, 1000);
    cfg_hot_thr = 2; cfg_cost_thr = 1; cfg_decay_period = 1;
    ex(16'h3000); ex(16'h3000);
    expect_out(0, 0, 0, "R10");
    ex(16'h3000);
    expect_out(1, 16'h3000, 0, "R10");

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule